// File: doc/BRIEF.md
# SPI Controller Register Bank

This block is the processor-facing side of a serial peripheral controller. It accepts 32-bit word accesses on a simple valid/write/address/data bus. Each access is decoded to one of nine registers: control, status, interrupt enable, configuration, DMA, period, and three data ports. The data ports are transmit data, message data and receive data. Writes to either transmit port queue words into a transmit FIFO. Reads of the receive port take words from a receive FIFO. The serial shifter is a separate block. It drains the transmit FIFO through a pop strobe, fills the receive FIFO through a push strobe, and reports the end of a transfer through a done strobe.

The status register reflects FIFO occupancy at all times. It also holds two sticky event flags, receive overflow and transfer complete, which software clears by writing ones. A level interrupt is raised while any status bit is set together with its enable bit. Writing the control register with its enable bit (bit 0) clear is a soft reset: every register returns to zero and both FIFOs are emptied.

Bus read replies come from a two-state machine. The state is BUS_IDLE or BUS_REPLY. A read request moves it to BUS_REPLY (transition REQ_READ). BUS_REPLY presents the read data with a valid flag for one cycle. The machine then returns to BUS_IDLE (transition REPLY_DONE), or stays in BUS_REPLY if a new read is requested in that cycle (transition BACK_TO_BACK).

Top module: `spi_host_regbank`

## Requirements
- R1: The register index is the byte address shifted right by two. The map is: 0 control, 1 status, 2 interrupt enable, 3 configuration, 4 transmit data, 5 receive data, 6 message data, 7 DMA, 8 period. An access whose address has either low bit set, or whose index is 9 or above, reads 0 and has no effect when written.
- R2: A read request on one clock edge produces `bus_rvalid` high with `bus_rdata` on the following cycle. `bus_rvalid` is low in every other cycle. A write takes effect on the edge that samples it.
- R3: Reading receive data returns 0 while control bit 0 is clear. It returns 0xDEADBEEF while the receive FIFO is empty. Otherwise it returns the oldest word and removes it, so words come back in push order.
- R4: Reads of transmit data and message data return 0. Writes to receive data change nothing.
- R5: A write to transmit data or message data appends the word to the transmit FIFO. The write is ignored while control bit 0 is clear or while the FIFO is full. `tx_valid` shows that the FIFO is non-empty, `tx_head` shows its oldest word, and `tx_pop` removes that word.
- R6: The status bits are: bit 0 transmit empty, bit 1 transmit request (constant 1), bit 2 transmit full, bit 3 receive ready (FIFO non-empty), bit 4 receive request (constant 0), bit 5 receive full. All other bits above 7 read 0.
- R7: A `rx_push` while the receive FIFO is full, and not being read in that cycle, drops the word and sets status bit 6 (overflow). A `done_set` pulse sets status bit 7 (transfer complete).
- R8: Writing the status register clears bit 6 or bit 7 wherever the written value has a 1. All other written bits are ignored. A set event in the same cycle wins over the clear.
- R9: `irq` is high exactly when some status bit and the same interrupt-enable bit are both 1.
- R10: Writing control with bit 0 clear zeroes every stored register, including control itself, and empties both FIFOs. Status then reads 0x00000003.
- R11: Control (written with bit 0 set), configuration, interrupt enable, DMA and period store the written word and read it back. Control and configuration also appear on `ctrl_out` and `cfg_out`.
- R12: After hardware reset, status reads 0x00000003, all other registers read 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read reply valid |
| irq | output | 1 | Level interrupt |
| tx_valid | output | 1 | Transmit FIFO non-empty |
| tx_head | output | DATA_W | Oldest transmit word |
| tx_pop | input | 1 | Shifter takes tx_head |
| rx_push | input | 1 | Shifter delivers a received word |
| rx_word | input | DATA_W | Received word |
| done_set | input | 1 | Transfer-complete strobe |
| ctrl_out | output | DATA_W | Control register contents |
| cfg_out | output | DATA_W | Configuration register contents |

## Verification
Read data is due in the cycle after the request edge. The bench registers the expected word in a queue when it drives the request, and a monitor compares the reply at the next falling edge. Writes, pushes, pops and strobes take effect on their sampling edge. Status, `irq`, `tx_valid` and `tx_head` change in that same cycle, so the bench checks them at the falling edge that ends the stimulus. A status read issued later then confirms the stored flags over the bus, one cycle after the request.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;

    localparam int REG_COUNT = 9;
    localparam int IDX_W     = 4;

    typedef enum logic [IDX_W-1:0] {
        RI_CTRL    = 4'd0,
        RI_STATUS  = 4'd1,
        RI_IEN     = 4'd2,
        RI_CONFIG  = 4'd3,
        RI_TXDATA  = 4'd4,
        RI_RXDATA  = 4'd5,
        RI_MSGDATA = 4'd6,
        RI_DMA     = 4'd7,
        RI_PERIOD  = 4'd8
    } reg_idx_e;

    // status bit positions
    localparam int SB_TX_EMPTY = 0;
    localparam int SB_TX_REQ   = 1;
    localparam int SB_TX_FULL  = 2;
    localparam int SB_RX_READY = 3;
    localparam int SB_RX_REQ   = 4;
    localparam int SB_RX_FULL  = 5;
    localparam int SB_RX_OVF   = 6;
    localparam int SB_DONE     = 7;

    localparam int CTRL_EN_BIT = 0;

    localparam logic [31:0] RX_EMPTY_WORD = 32'hDEAD_BEEF;

    typedef enum logic {
        BUS_IDLE  = 1'b0,
        BUS_REPLY = 1'b1
    } bus_state_e;

endpackage

// File: rtl/spi_rb_fifo.sv
module spi_rb_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;
    logic             do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CAP);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push && !flush) begin
            mem[wp] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) begin
                wp <= (wp == LAST) ? '0 : wp + 1'b1;
            end
            if (do_pop) begin
                rp <= (rp == LAST) ? '0 : rp + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/spi_rb_decode.sv
module spi_rb_decode
    import spi_rb_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic                 hit,
    output logic [IDX_W-1:0]     idx,
    output logic [REG_COUNT-1:0] sel
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              aligned;

    assign word    = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);
    assign hit     = aligned && (word < WORD_W'(REG_COUNT));
    assign idx     = hit ? word[IDX_W-1:0] : '0;

    for (genvar i = 0; i < REG_COUNT; i++) begin : g_sel
        assign sel[i] = hit && (word == WORD_W'(i));
    end

endmodule

// File: rtl/spi_rb_status.sv
module spi_rb_status
    import spi_rb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_all,
    input  logic              tx_empty,
    input  logic              tx_full,
    input  logic              rx_empty,
    input  logic              rx_full,
    input  logic              ovf_set,
    input  logic              done_set,
    input  logic              w1c_ovf,
    input  logic              w1c_done,
    input  logic [DATA_W-1:0] ien,
    output logic [DATA_W-1:0] status,
    output logic              irq
);
    logic ovf_q, done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q  <= 1'b0;
            done_q <= 1'b0;
        end else if (clear_all) begin
            ovf_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            ovf_q  <= ovf_set  || (ovf_q  && !w1c_ovf);
            done_q <= done_set || (done_q && !w1c_done);
        end
    end

    always_comb begin
        status              = '0;
        status[SB_TX_EMPTY] = tx_empty;
        status[SB_TX_REQ]   = 1'b1;
        status[SB_TX_FULL]  = tx_full;
        status[SB_RX_READY] = !rx_empty;
        status[SB_RX_REQ]   = 1'b0;
        status[SB_RX_FULL]  = rx_full;
        status[SB_RX_OVF]   = ovf_q;
        status[SB_DONE]     = done_q;
    end

    assign irq = |(status & ien);

endmodule

// File: rtl/spi_host_regbank.sv
module spi_host_regbank
    import spi_rb_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int FIFO_DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              irq,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_head,
    input  logic              tx_pop,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_word,
    input  logic              done_set,
    output logic [DATA_W-1:0] ctrl_out,
    output logic [DATA_W-1:0] cfg_out
);
    // ---------------- decode ----------------
    logic                 hit;
    logic [IDX_W-1:0]     idx;
    logic [REG_COUNT-1:0] sel;

    spi_rb_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .hit  (hit),
        .idx  (idx),
        .sel  (sel)
    );

    logic rd_req, wr_req;
    logic sel_ctrl, sel_stat, sel_rx, sel_tx_any;

    assign rd_req     = bus_valid && !bus_write;
    assign wr_req     = bus_valid && bus_write;
    assign sel_ctrl   = sel[RI_CTRL];
    assign sel_stat   = sel[RI_STATUS];
    assign sel_rx     = sel[RI_RXDATA];
    assign sel_tx_any = sel[RI_TXDATA] || sel[RI_MSGDATA];

    // ---------------- stored registers ----------------
    logic [DATA_W-1:0] ctrl_q, ien_q, cfg_q, dma_q, period_q;
    logic              enabled, soft_rst;

    assign enabled  = ctrl_q[CTRL_EN_BIT];
    assign soft_rst = wr_req && sel_ctrl && !bus_wdata[CTRL_EN_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            ien_q    <= '0;
            cfg_q    <= '0;
            dma_q    <= '0;
            period_q <= '0;
        end else if (soft_rst) begin
            ctrl_q   <= '0;
            ien_q    <= '0;
            cfg_q    <= '0;
            dma_q    <= '0;
            period_q <= '0;
        end else if (wr_req) begin
            if (sel_ctrl)         ctrl_q   <= bus_wdata;
            if (sel[RI_IEN])      ien_q    <= bus_wdata;
            if (sel[RI_CONFIG])   cfg_q    <= bus_wdata;
            if (sel[RI_DMA])      dma_q    <= bus_wdata;
            if (sel[RI_PERIOD])   period_q <= bus_wdata;
        end
    end

    // ---------------- FIFOs ----------------
    logic              tx_empty, tx_full, rx_empty, rx_full;
    logic              tx_push, rx_pop, ovf_set;
    logic [DATA_W-1:0] rx_head;

    assign tx_push = wr_req && sel_tx_any && enabled && !tx_full;
    assign rx_pop  = rd_req && sel_rx && enabled && !rx_empty;
    assign ovf_set = rx_push && rx_full && !rx_pop;

    spi_rb_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (soft_rst),
        .push  (tx_push),
        .wdata (bus_wdata),
        .pop   (tx_pop),
        .head  (tx_head),
        .empty (tx_empty),
        .full  (tx_full)
    );

    spi_rb_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (soft_rst),
        .push  (rx_push),
        .wdata (rx_word),
        .pop   (rx_pop),
        .head  (rx_head),
        .empty (rx_empty),
        .full  (rx_full)
    );

    // ---------------- status and interrupt ----------------
    logic [DATA_W-1:0] status_w;

    spi_rb_status #(.DATA_W(DATA_W)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_all (soft_rst),
        .tx_empty  (tx_empty),
        .tx_full   (tx_full),
        .rx_empty  (rx_empty),
        .rx_full   (rx_full),
        .ovf_set   (ovf_set),
        .done_set  (done_set),
        .w1c_ovf   (wr_req && sel_stat && bus_wdata[SB_RX_OVF]),
        .w1c_done  (wr_req && sel_stat && bus_wdata[SB_DONE]),
        .ien       (ien_q),
        .status    (status_w),
        .irq       (irq)
    );

    // ---------------- read mux ----------------
    logic [DATA_W-1:0] rd_value;

    always_comb begin
        rd_value = '0;
        if (hit) begin
            unique case (reg_idx_e'(idx))
                RI_CTRL:    rd_value = ctrl_q;
                RI_STATUS:  rd_value = status_w;
                RI_IEN:     rd_value = ien_q;
                RI_CONFIG:  rd_value = cfg_q;
                RI_DMA:     rd_value = dma_q;
                RI_PERIOD:  rd_value = period_q;
                RI_RXDATA: begin
                    if (!enabled)      rd_value = '0;
                    else if (rx_empty) rd_value = DATA_W'(RX_EMPTY_WORD);
                    else               rd_value = rx_head;
                end
                default:    rd_value = '0;
            endcase
        end
    end

    // ---------------- bus reply machine ----------------
    bus_state_e        state_q, state_d;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE:  state_d = rd_req ? BUS_REPLY : BUS_IDLE;
            BUS_REPLY: state_d = rd_req ? BUS_REPLY : BUS_IDLE;
            default:   state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            rdata_q <= rd_req ? rd_value : '0;
        end
    end

    always_comb begin
        bus_rvalid = (state_q == BUS_REPLY);
        bus_rdata  = rdata_q;
    end

    assign tx_valid = !tx_empty;
    assign ctrl_out = ctrl_q;
    assign cfg_out  = cfg_q;

endmodule

// File: rtl/spi_rb_checker.sv
module spi_rb_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic              bus_rvalid,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              sel_rx,
    input logic              sel_tx_any,
    input logic              sel_stat,
    input logic              enabled,
    input logic              tx_full,
    input logic              tx_pop,
    input logic              soft_rst,
    input logic              rx_push,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] status_w,
    input logic [DATA_W-1:0] ctrl_q
);
    // R2
    rvalid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> bus_rvalid);

    // R2
    no_stray_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> !bus_rvalid);

    // R3
    rx_disabled_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && sel_rx && !enabled) |=> (bus_rdata == '0));

    // R5
    tx_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && sel_tx_any && tx_full && !tx_pop) |=> tx_full);

    // R8
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && sel_stat && bus_wdata[6] && !rx_push) |=> !status_w[6]);

    // R10
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (status_w == 32'h0000_0003 && ctrl_q == '0));

    // R6
    tx_flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(status_w[0] && status_w[2]));

endmodule

bind spi_host_regbank spi_rb_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_rvalid (bus_rvalid),
    .bus_rdata  (bus_rdata),
    .sel_rx     (sel_rx),
    .sel_tx_any (sel_tx_any),
    .sel_stat   (sel_stat),
    .enabled    (enabled),
    .tx_full    (tx_full),
    .tx_pop     (tx_pop),
    .soft_rst   (soft_rst),
    .rx_push    (rx_push),
    .bus_wdata  (bus_wdata),
    .status_w   (status_w),
    .ctrl_q     (ctrl_q)
);

// File: tb/spi_host_regbank_test.sv
module spi_host_regbank_test;
    localparam int DEPTH = 64;
    localparam logic [11:0] A_CTRL = 12'h000, A_STAT = 12'h004, A_IEN = 12'h008,
                            A_CFG = 12'h00C, A_TX = 12'h010, A_RX = 12'h014,
                            A_MSG = 12'h018, A_DMA = 12'h01C, A_PER = 12'h020;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_valid, bus_write;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata, tx_head, rx_word, ctrl_out, cfg_out;
    logic        bus_rvalid, irq, tx_valid, tx_pop, rx_push, done_set;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    spi_host_regbank #(.ADDR_W(12), .DATA_W(32), .FIFO_DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .irq(irq), .tx_valid(tx_valid), .tx_head(tx_head),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word), .done_set(done_set),
        .ctrl_out(ctrl_out), .cfg_out(cfg_out)
    );

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor: one reply due per queued expectation
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                n_checks++;
                n_errors++;
                $display("FAIL R2 unexpected reply actual=%h expected=none", bus_rdata);
            end else begin
                check_eq(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic pop_tx();
        @(negedge clk); tx_pop = 1'b1;
        @(negedge clk); tx_pop = 1'b0;
    endtask

    task automatic push_rx(input logic [31:0] w);
        @(negedge clk); rx_push = 1'b1; rx_word = w;
        @(negedge clk); rx_push = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); done_set = 1'b1;
        @(negedge clk); done_set = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
        tx_pop = 1'b0; rx_push = 1'b0; rx_word = '0; done_set = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        check_eq("R12 irq after reset", 32'(irq), 32'h0);
        rd(A_STAT, 32'h3, "R12 status after reset");
        rd(A_CTRL, 32'h0, "R12 control after reset");
        rd(A_CFG, 32'h0, "R12 config after reset");

        // R3 disabled read, R5 write while disabled ignored
        rd(A_RX, 32'h0, "R3 rx read while disabled");
        wr(A_TX, 32'h5555_0000);
        check_eq("R5 tx write while disabled", 32'(tx_valid), 32'h0);

        // R11 storage
        wr(A_CTRL, 32'h0000_0F01);
        check_eq("R11 ctrl_out", ctrl_out, 32'h0000_0F01);
        rd(A_CTRL, 32'h0000_0F01, "R11 control readback");
        wr(A_CFG, 32'hA5A5_0F0F);
        check_eq("R11 cfg_out", cfg_out, 32'hA5A5_0F0F);
        rd(A_CFG, 32'hA5A5_0F0F, "R11 config readback");
        wr(A_DMA, 32'h1234_5678);
        rd(A_DMA, 32'h1234_5678, "R11 dma readback");
        wr(A_PER, 32'h0000_BEEF);
        rd(A_PER, 32'h0000_BEEF, "R11 period readback");

        // R1 misaligned / out of range
        wr(A_CFG + 12'h1, 32'h0000_0BAD);
        rd(A_CFG, 32'hA5A5_0F0F, "R1 misaligned write dropped");
        rd(A_CFG + 12'h2, 32'h0, "R1 misaligned read");
        rd(12'h050, 32'h0, "R1 out-of-range read");
        wr(12'h024, 32'hFFFF_FFFF);
        rd(A_STAT, 32'h3, "R1 out-of-range write no effect");

        // R3 empty pattern
        rd(A_RX, 32'hDEAD_BEEF, "R3 rx empty pattern");

        // R5 / R4 tx path
        wr(A_TX, 32'h1111_1111);
        wr(A_MSG, 32'h2222_2222);
        check_eq("R5 tx_head first", tx_head, 32'h1111_1111);
        rd(A_STAT, 32'h2, "R6 status tx non-empty");
        rd(A_TX, 32'h0, "R4 tx data read zero");
        rd(A_MSG, 32'h0, "R4 msg data read zero");
        pop_tx();
        check_eq("R5 tx_head second", tx_head, 32'h2222_2222);
        pop_tx();
        check_eq("R5 tx drained", 32'(tx_valid), 32'h0);

        // R3 rx path order, R4 write to rx ignored
        push_rx(32'hCAFE_0001);
        push_rx(32'hCAFE_0002);
        rd(A_STAT, 32'hB, "R6 status rx ready");
        rd(A_RX, 32'hCAFE_0001, "R3 rx first");
        rd(A_RX, 32'hCAFE_0002, "R3 rx second");
        wr(A_RX, 32'h0000_1234);
        rd(A_RX, 32'hDEAD_BEEF, "R4 rx write ignored");

        // R9 interrupt
        wr(A_IEN, 32'h1);
        check_eq("R9 irq on tx empty", 32'(irq), 32'h1);
        rd(A_IEN, 32'h1, "R11 ien readback");
        wr(A_IEN, 32'h0);
        check_eq("R9 irq masked", 32'(irq), 32'h0);

        // R7 done, R8 w1c
        pulse_done();
        rd(A_STAT, 32'h83, "R7 done sets bit 7");
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, 32'h3, "R8 w1c clears only sticky bits");
        wr(A_IEN, 32'h80);
        pulse_done();
        check_eq("R9 irq on done", 32'(irq), 32'h1);
        wr(A_STAT, 32'h80);
        check_eq("R9 irq after clear", 32'(irq), 32'h0);

        // R7 overflow
        for (int i = 0; i < DEPTH; i++) push_rx(32'hCAFE_0100 + i);
        rd(A_STAT, 32'h2B, "R6 rx full");
        push_rx(32'hBAD0_BAD0);
        rd(A_STAT, 32'h6B, "R7 overflow set");
        wr(A_STAT, 32'h40);
        rd(A_STAT, 32'h2B, "R8 overflow cleared");

        // R5 tx full, write ignored
        for (int i = 0; i < DEPTH; i++) wr(A_TX, 32'h1000_0000 + i);
        rd(A_STAT, 32'h2E, "R6 tx full");
        wr(A_MSG, 32'hEEEE_EEEE);
        for (int i = 0; i < DEPTH; i++) begin
            check_eq("R5 tx order", tx_head, 32'h1000_0000 + i);
            pop_tx();
        end
        check_eq("R5 extra word dropped", 32'(tx_valid), 32'h0);
        rd(A_STAT, 32'h2B, "R6 tx empty again");
        rd(A_RX, 32'hCAFE_0100, "R3 rx oldest after fill");
        rd(A_RX, 32'hCAFE_0101, "R3 rx next after fill");
        rd(A_STAT, 32'hB, "R6 rx no longer full");

        // R10 soft reset
        wr(A_TX, 32'h7777_7777);
        pulse_done();
        wr(A_IEN, 32'h81);
        wr(A_CTRL, 32'hFFFF_FFFE);
        check_eq("R10 tx flushed", 32'(tx_valid), 32'h0);
        check_eq("R10 irq low", 32'(irq), 32'h0);
        rd(A_STAT, 32'h3, "R10 status after soft reset");
        rd(A_CTRL, 32'h0, "R10 control zero");
        rd(A_CFG, 32'h0, "R10 config zero");
        rd(A_IEN, 32'h0, "R10 ien zero");
        rd(A_DMA, 32'h0, "R10 dma zero");

        // R8 set wins over clear in same cycle
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h80;
        done_set = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; done_set = 1'b0;
        rd(A_STAT, 32'h83, "R8 set wins over clear");

        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule